// File: doc/BRIEF.md
# Command/Indication Channel Transceiver

This block serves the four-bit command/indication field carried in each frame of a time-multiplexed serial link. On the transmit side the host writes a code once. The block then shifts that code out, MSB first, in every frame until the host writes a different one. On the receive side the block shifts in the same field each frame and feeds it to a debounce filter. The filter accepts a new code only when the code differs from the one already accepted and has arrived unchanged in two frames in a row. An accepted code lands in a readable register and sets a pending flag, which drives the interrupt line when the host has enabled it.

A frame strobe marks the start of each frame. A bit-enable pulse, shared by transmit and receive, marks each bit of the field. Frame timing itself comes from outside the block. A loopback setting feeds the transmitted bits back into the receiver. A second setting lets loopback run with the outgoing line held idle, so the line shows nothing while the test runs.

Top module: `ci_transceiver`

## Requirements
- R1: After reset the accepted code reads 4'hF, the pending flag is 0, the control register reads 0, `irq` is 0 and `txd` is 1.
- R2: With transmit enabled, each frame sends the stored transmit code MSB first, one bit per `bit_en` pulse after `frame_sync`. The same code is sent again in every later frame. Once the field has been sent, `txd` returns to 1.
- R3: With transmit disabled (control bit 0 clear), `txd` stays at 1 for the whole field.
- R4: A received code different from the accepted code becomes the accepted code only after it has been received in two consecutive frames. Acceptance sets the pending flag.
- R5: A received code equal to the accepted code is never accepted. It also discards any candidate waiting for a second frame.
- R6: When a frame's code differs from the candidate of the previous frame, it replaces the candidate and nothing is accepted.
- R7: The pending flag is status bit 0. Writing 1 to that bit clears it. `irq` equals the pending flag AND control bit 4. With bit 4 clear, the flag still sets but `irq` stays 0.
- R8: While receive is disabled (control bit 1 clear), frames have no effect: the accepted code and the pending flag do not change.
- R9: With loopback set (control bit 2), the receiver takes the transmitted bits and ignores `rxd`.
- R10: With loopback and line-quiet (control bit 3) both set, `txd` stays at 1 while the receiver still sees the transmitted bits. Line-quiet has no effect without loopback.
- R11: `bit_en` pulses beyond the fourth in a frame are ignored by both directions.
- R12: Register map on `host_addr`: 0 control (read/write: bit0 transmit enable, bit1 receive enable, bit2 loopback, bit3 line-quiet, bit4 interrupt enable); 1 transmit code (read/write, bits 3:0); 2 accepted code (read-only, bits 3:0); 3 status (bit0 pending, write 1 to clear). `host_rdata` follows `host_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_sync | input | 1 | One-cycle strobe at the start of each frame |
| bit_en | input | 1 | One-cycle strobe per bit of the command/indication field |
| rxd | input | 1 | Serial receive data, sampled on `bit_en` |
| txd | output | 1 | Serial transmit data, idles high |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 2 | Host register select |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for the selected register |
| irq | output | 1 | Maskable interrupt: a new code has been accepted |

## Verification
The bench walks the filter through sequences that set its corner cases apart: one frame of a new code (a filter that accepts at once would update here), a code that flips between frames (a filter that keeps the stale candidate would accept the wrong value), and a return to the accepted code between two frames of another code (a filter that keeps the candidate would accept early). It also sends frames with surplus bit pulses, which a counter without an end stop would shift into the code. It checks that masking the interrupt leaves the pending flag set. Finally it runs loopback with `rxd` driven to the opposite code and with the line held quiet, which catches a receive mux or output gate wired to the wrong control bit.

// File: rtl/ci_pkg.sv
`timescale 1ns/1ps
// Shared register selects and control-word layout for the C/I transceiver.
package ci_pkg;
    localparam int unsigned REG_ADDR_W = 2;

    typedef enum logic [REG_ADDR_W-1:0] {
        REG_CTRL   = 2'd0,
        REG_TXCODE = 2'd1,
        REG_RXCODE = 2'd2,
        REG_STAT   = 2'd3
    } reg_sel_e;

    // Packed so that tx_en is bit 0 and irq_en is bit 4 of the control register.
    typedef struct packed {
        logic irq_en;
        logic quiet;
        logic loop;
        logic rx_en;
        logic tx_en;
    } ctrl_t;

    localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/ci_host_regs.sv
`timescale 1ns/1ps
// Host register file: control word, transmit code and pending flag.
// Assumes DATA_W >= CTRL_W and DATA_W >= CI_W. Reads are combinational.
module ci_host_regs
    import ci_pkg::*;
#(
    parameter int unsigned CI_W   = 4,
    parameter int unsigned DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [CI_W-1:0]       acc_code,
    input  logic                  acc_stb,
    output logic [DATA_W-1:0]     rdata,
    output ctrl_t                 ctrl,
    output logic [CI_W-1:0]       tx_code,
    output logic                  pending
);
    localparam int unsigned CTRL_PAD = DATA_W - CTRL_W;
    localparam int unsigned CODE_PAD = DATA_W - CI_W;

    logic clr_req;
    assign clr_req = wr_en && (addr == REG_STAT) && wdata[0];

    // Control and transmit code registers, written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl    <= '0;
            tx_code <= '1;
        end else if (wr_en) begin
            if (addr == REG_CTRL)   ctrl    <= ctrl_t'(wdata[CTRL_W-1:0]);
            if (addr == REG_TXCODE) tx_code <= wdata[CI_W-1:0];
        end
    end

    // Pending flag: set by acceptance, cleared by write-one; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)       pending <= 1'b0;
        else if (acc_stb) pending <= 1'b1;
        else if (clr_req) pending <= 1'b0;
    end

    // Read mux over the four registers.
    always_comb begin
        unique case (reg_sel_e'(addr))
            REG_CTRL:   rdata = {{CTRL_PAD{1'b0}}, ctrl};
            REG_TXCODE: rdata = {{CODE_PAD{1'b0}}, tx_code};
            REG_RXCODE: rdata = {{CODE_PAD{1'b0}}, acc_code};
            default:    rdata = {{(DATA_W-1){1'b0}}, pending};
        endcase
    end

    // R7: a clear write with no acceptance in flight empties the flag.
    a_r7_clear_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !acc_stb) |=> !pending);
    // R7: every acceptance strobe leaves the flag set.
    a_r7_set_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        acc_stb |=> pending);
endmodule

// File: rtl/ci_tx_shifter.sv
`timescale 1ns/1ps
// Transmit shifter: loads the code at each frame strobe and shifts it out MSB
// first, one bit per bit_en, refilling with ones. Assumes CI_W >= 2.
module ci_tx_shifter #(
    parameter int unsigned CI_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_sync,
    input  logic            bit_en,
    input  logic            tx_en,
    input  logic [CI_W-1:0] code,
    output logic            tx_bit
);
    localparam int unsigned CNT_W = $clog2(CI_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CI_W);

    logic [CI_W-1:0]  shreg;
    logic [CNT_W-1:0] cnt;

    // Frame load and per-bit shift; the count stops at CI_W.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '1;
            cnt   <= LAST;
        end else if (frame_sync) begin
            shreg <= code;
            cnt   <= '0;
        end else if (bit_en && (cnt < LAST)) begin
            shreg <= {shreg[CI_W-2:0], 1'b1};
            cnt   <= cnt + CNT_W'(1);
        end
    end

    // Disabled transmitter presents idle ones.
    assign tx_bit = tx_en ? shreg[CI_W-1] : 1'b1;

    // R2: the shifter moves only on a frame strobe or a bit pulse.
    a_r2_hold_between_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_en && !frame_sync) |=> $stable(shreg));
    // R11: surplus bit pulses after the field leave the shifter alone.
    a_r11_tx_extra_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !frame_sync && (cnt == LAST)) |=> $stable(shreg));
endmodule

// File: rtl/ci_rx_deser.sv
`timescale 1ns/1ps
// Receive deserializer: collects CI_W bits MSB first after each frame strobe
// and emits the code with a one-cycle strobe. Assumes CI_W >= 2.
module ci_rx_deser #(
    parameter int unsigned CI_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_sync,
    input  logic            bit_en,
    input  logic            din,
    output logic            code_stb,
    output logic [CI_W-1:0] code
);
    localparam int unsigned CNT_W = $clog2(CI_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CI_W);
    localparam logic [CNT_W-1:0] FINAL_BIT = CNT_W'(CI_W - 1);

    logic [CI_W-1:0]  shreg;
    logic [CNT_W-1:0] cnt;

    // Bit collection; the last bit of the field publishes the code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg    <= '1;
            cnt      <= LAST;
            code     <= '1;
            code_stb <= 1'b0;
        end else begin
            code_stb <= 1'b0;
            if (frame_sync) begin
                cnt <= '0;
            end else if (bit_en && (cnt < LAST)) begin
                shreg <= {shreg[CI_W-2:0], din};
                cnt   <= cnt + CNT_W'(1);
                if (cnt == FINAL_BIT) begin
                    code     <= {shreg[CI_W-2:0], din};
                    code_stb <= 1'b1;
                end
            end
        end
    end

    // R11: at most one code per frame, so the strobe never repeats back to back.
    a_r11_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        code_stb |=> !code_stb);
endmodule

// File: rtl/ci_rx_filter.sv
`timescale 1ns/1ps
// Debounce filter: a code differing from the accepted one must arrive in two
// consecutive frames before it is accepted. Ignores frames while disabled.
module ci_rx_filter #(
    parameter int unsigned CI_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx_en,
    input  logic            code_stb,
    input  logic [CI_W-1:0] code,
    output logic [CI_W-1:0] accepted,
    output logic            acc_stb
);
    logic [CI_W-1:0] cand;
    logic            cand_vld;

    // Candidate tracking and acceptance on each delivered frame code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            accepted <= '1;
            cand     <= '1;
            cand_vld <= 1'b0;
            acc_stb  <= 1'b0;
        end else begin
            acc_stb <= 1'b0;
            if (code_stb && rx_en) begin
                if (code == accepted) begin
                    cand_vld <= 1'b0;
                end else if (cand_vld && (code == cand)) begin
                    accepted <= code;
                    acc_stb  <= 1'b1;
                    cand_vld <= 1'b0;
                end else begin
                    cand     <= code;
                    cand_vld <= 1'b1;
                end
            end
        end
    end

    // R4: the accepted code never changes without the acceptance strobe.
    a_r4_change_has_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(accepted) |-> acc_stb);
    // R5: a frame carrying the accepted code produces no acceptance.
    a_r5_same_not_accepted: assert property (@(posedge clk) disable iff (!rst_n)
        (code_stb && (code == accepted)) |=> !acc_stb);
    // R8: with receive disabled the accepted code holds.
    a_r8_disabled_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> $stable(accepted));
endmodule

// File: rtl/ci_transceiver.sv
`timescale 1ns/1ps
// Command/indication channel transceiver top. Joins the host registers, the
// transmit shifter, the receive deserializer and the debounce filter, and
// applies the loopback and line-quiet routing. frame_sync and bit_en come
// from the frame timing logic outside this block.
module ci_transceiver
    import ci_pkg::*;
#(
    parameter int unsigned CI_W   = 4,
    parameter int unsigned DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frame_sync,
    input  logic                  bit_en,
    input  logic                  rxd,
    output logic                  txd,
    input  logic                  host_wr,
    input  logic [REG_ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0]     host_wdata,
    output logic [DATA_W-1:0]     host_rdata,
    output logic                  irq
);
    ctrl_t           ctrl;
    logic [CI_W-1:0] tx_code;
    logic [CI_W-1:0] rx_code;
    logic [CI_W-1:0] acc_code;
    logic            pending;
    logic            acc_stb;
    logic            rx_stb;
    logic            tx_bit;
    logic            rx_in;

    ci_host_regs #(.CI_W(CI_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(host_wr), .addr(host_addr),
        .wdata(host_wdata), .acc_code(acc_code), .acc_stb(acc_stb),
        .rdata(host_rdata), .ctrl(ctrl), .tx_code(tx_code), .pending(pending)
    );

    ci_tx_shifter #(.CI_W(CI_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .bit_en(bit_en),
        .tx_en(ctrl.tx_en), .code(tx_code), .tx_bit(tx_bit)
    );

    // Receiver source: the transmitted bit in loopback, else the line.
    assign rx_in = ctrl.loop ? tx_bit : rxd;

    ci_rx_deser #(.CI_W(CI_W)) u_deser (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .bit_en(bit_en),
        .din(rx_in), .code_stb(rx_stb), .code(rx_code)
    );

    ci_rx_filter #(.CI_W(CI_W)) u_filt (
        .clk(clk), .rst_n(rst_n), .rx_en(ctrl.rx_en), .code_stb(rx_stb),
        .code(rx_code), .accepted(acc_code), .acc_stb(acc_stb)
    );

    // Line output, held idle when loopback runs quiet.
    assign txd = (ctrl.loop && ctrl.quiet) ? 1'b1 : tx_bit;
    assign irq = pending & ctrl.irq_en;

    // R10: a quiet loopback never drives a zero onto the line.
    a_r10_quiet_line_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.loop && ctrl.quiet) |-> txd);
    // R7: the interrupt line never rises without a pending flag.
    a_r7_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> pending);
endmodule

// File: tb/tb_ci_transceiver.sv
`timescale 1ns/1ps
module tb_ci_transceiver;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_sync = 1'b0;
    logic       bit_en = 1'b0;
    logic       rxd = 1'b1;
    logic       txd;
    logic       host_wr = 1'b0;
    logic [1:0] host_addr = 2'd0;
    logic [7:0] host_wdata = 8'd0;
    logic [7:0] host_rdata;
    logic       irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    ci_transceiver dut (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .bit_en(bit_en),
        .rxd(rxd), .txd(txd), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq)
    );

    // Vector: {frame code, expected accepted code, expected irq}; start value 4'hF.
    localparam logic [8:0] VEC [14] = '{
        {4'h5, 4'hF, 1'b0},  // R4 one frame is not enough
        {4'h5, 4'h5, 1'b1},  // R4 second frame accepts
        {4'h5, 4'h5, 1'b0},  // R5 same as accepted
        {4'hA, 4'h5, 1'b0},  // R4 new candidate
        {4'h3, 4'h5, 1'b0},  // R6 candidate replaced
        {4'h3, 4'h3, 1'b1},  // R6 replacement accepted
        {4'hF, 4'h3, 1'b0},  // R4 candidate F
        {4'h3, 4'h3, 1'b0},  // R5 back to accepted drops candidate
        {4'hF, 4'h3, 1'b0},  // R5 F must start over
        {4'hF, 4'hF, 1'b1},  // R4 accepted
        {4'h0, 4'hF, 1'b0},  // R4 candidate 0
        {4'hF, 4'hF, 1'b0},  // R5 drops candidate
        {4'h0, 4'hF, 1'b0},  // R5 starts over
        {4'h0, 4'h0, 1'b1}   // R4 accepted
    };

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    // One frame: strobe, then nbits bit pulses; captures txd before each of the first four.
    task automatic send_frame(input logic [3:0] code, input int nbits, output logic [3:0] seen);
        @(negedge clk) frame_sync = 1'b1;
        @(negedge clk) frame_sync = 1'b0;
        seen = 4'h0;
        for (int i = 0; i < nbits; i++) begin
            if (i < 4) seen[3-i] = txd;
            rxd = (i < 4) ? code[3-i] : 1'b0;
            bit_en = 1'b1;
            @(negedge clk) bit_en = 1'b0;
            @(negedge clk);
        end
        rxd = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(1_000_000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        logic [3:0] seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        host_read(2'd2, rd); check("R1 accepted", rd, 8'h0F);
        host_read(2'd3, rd); check("R1 pending", rd, 8'h00);
        host_read(2'd0, rd); check("R1 control", rd, 8'h00);
        check("R1 irq", irq, 0);
        check("R1 txd", txd, 1);

        // R12 control readback
        host_write(2'd0, 8'h12);
        host_read(2'd0, rd); check("R12 control readback", rd, 8'h12);

        // Filter table: R4 R5 R6
        foreach (VEC[k]) begin
            send_frame(VEC[k][8:5], 4, seen);
            host_read(2'd2, rd);
            check($sformatf("R4/R5/R6 row %0d accepted", k), rd, VEC[k][4:1]);
            check($sformatf("R4/R7 row %0d irq", k), irq, VEC[k][0]);
            if (VEC[k][0]) host_write(2'd3, 8'h01);
        end

        // R11 surplus bit pulses ignored (accepted is 0)
        send_frame(4'h5, 6, seen);
        host_read(2'd2, rd); check("R11 one long frame", rd, 8'h00);
        send_frame(4'h5, 6, seen);
        host_read(2'd2, rd); check("R11 two long frames", rd, 8'h05);
        host_write(2'd3, 8'h01);

        // R7 masking and write-one clear
        host_write(2'd0, 8'h02);
        send_frame(4'h7, 4, seen);
        send_frame(4'h7, 4, seen);
        check("R7 masked irq", irq, 0);
        host_read(2'd3, rd); check("R7 pending while masked", rd, 8'h01);
        host_write(2'd0, 8'h12);
        @(negedge clk); check("R7 unmasked irq", irq, 1);
        host_write(2'd3, 8'h01);
        @(negedge clk); check("R7 irq after clear", irq, 0);
        host_read(2'd3, rd); check("R7 pending after clear", rd, 8'h00);

        // R8 receive disabled
        host_write(2'd0, 8'h10);
        send_frame(4'h6, 4, seen);
        send_frame(4'h6, 4, seen);
        host_read(2'd2, rd); check("R8 accepted held", rd, 8'h07);
        host_read(2'd3, rd); check("R8 no pending", rd, 8'h00);

        // R2 transmit repeats; R12 transmit code readback
        host_write(2'd0, 8'h11);
        host_write(2'd1, 8'h09);
        host_read(2'd1, rd); check("R12 tx code readback", rd, 8'h09);
        send_frame(4'hF, 4, seen); check("R2 first frame", seen, 4'h9);
        check("R2 idle after field", txd, 1);
        send_frame(4'hF, 4, seen); check("R2 repeat frame", seen, 4'h9);

        // R3 transmit disabled
        host_write(2'd0, 8'h10);
        send_frame(4'hF, 4, seen); check("R3 disabled line", seen, 4'hF);

        // R10 quiet without loopback has no effect
        host_write(2'd0, 8'h19);
        send_frame(4'hF, 4, seen); check("R10 quiet without loop", seen, 4'h9);

        // R9 loopback ignores rxd
        host_write(2'd0, 8'h17);
        host_write(2'd1, 8'h06);
        send_frame(4'h9, 4, seen); check("R9 line shows tx", seen, 4'h6);
        send_frame(4'h9, 4, seen);
        host_read(2'd2, rd); check("R9 loopback accepted", rd, 8'h06);
        check("R9 irq", irq, 1);
        host_write(2'd3, 8'h01);

        // R10 quiet loopback
        host_write(2'd0, 8'h1F);
        host_write(2'd1, 8'h0C);
        send_frame(4'h3, 4, seen); check("R10 quiet line", seen, 4'hF);
        send_frame(4'h3, 4, seen);
        host_read(2'd2, rd); check("R10 quiet loop accepted", rd, 8'h0C);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule